// File: doc/BRIEF.md
# SDRAM Power-State Manager

This block sits between the request front end of an SDRAM controller and its command sequencer. It decides when the external memory goes into a low-power state and when it comes back out. A 32-bit configuration word, written through a simple write port and readable on `cfg_o`, selects the behaviour.

While no request is pending, an idle down-counter runs. When it expires, the block either gates the controller's internal clock or puts the memory into self-refresh. Self-refresh can also be entered on a warm reset request or on a hardware idle request, each enabled by its own bit. The block drives the memory clock-enable (CKE) for power-down and gates the clock to the external memory.

A pending request takes the block out of the clock-gated or self-refresh state. After that wakeup, the first access is held back. It is released either after a fixed number of controller cycles or when a DLL lock indication arrives.

Top module: `sdram_pwr_mgr`

Configuration word fields (all other bits read 0):

| Bit(s) | Field |
|---|---|
| 0 | page policy, stored only |
| 2 | power-down allow |
| 3 | external clock disable |
| 5:4 | mode |
| 6 | self-refresh on idle request |
| 7 | self-refresh on warm reset |
| 23:8 | idle count N |
| 26 | wake select |

The reset value of the configuration word is 0x0000_0085.

## Requirements
- R1: After reset `cfg_o` reads 0x0000_0085. Writing 0xFFFF_FFFF reads back 0x04FF_FFFD, and writing 0 reads back 0: reserved bits 31:27, 25:24 and 1 always read 0.
- R2: With mode = 1, the block gates the internal clock. `int_clk_en_o` goes low at the (N+1)-th rising edge after `req_pending_i` falls, and `ext_clk_en_o` stays 1.
- R3: With mode = 2, the block enters self-refresh at the (N+1)-th idle edge. In the first self-refresh cycle `srf_enter_o` is 1 for one cycle. Throughout self-refresh, `cke_o`, `ext_clk_en_o` and `int_clk_en_o` are 0.
- R4: Mode 0 and mode 3 never enter a low-power state on idle. `int_clk_en_o` and `cke_o` stay 1.
- R5: Any cycle with `req_pending_i` high reloads the idle counter, so the N+1 count restarts from the last pending cycle.
- R6: With bit 7 = 1, `warm_rst_req_i` enters self-refresh on the next edge. With bit 7 = 0, it has no effect on `cke_o`.
- R7: With bit 6 = 1, `idle_req_i` enters self-refresh, and `idle_ack_o` is 1 only while in self-refresh with the external clock stopped. With bit 6 = 0, `idle_ack_o` stays 0 and `cke_o` stays 1.
- R8: A pending request in self-refresh leads to exit. In the first wake cycle `srf_exit_o` is 1 for one cycle, `cke_o` is 1 and `req_grant_o` is 0.
- R9: With bit 26 = 0, `req_grant_o` rises exactly STALL_CYCLES (default 500) edges after the wake state is entered. This applies to wakeups from both clock gating and self-refresh.
- R10: With bit 26 = 1, the stall lasts until `dll_lock_i` is high. Grant follows on the next edge.
- R11: In the clock-gated state, `cke_o` is 0 when bit 2 = 1 and 1 when bit 2 = 0.
- R12: With bit 3 = 1, `ext_clk_en_o` is 0 in every state.
- R13: `req_grant_o` is 1 only in the active state with `req_pending_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | controller clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| cfg_we_i | input | 1 | configuration write strobe |
| cfg_wdata_i | input | 32 | configuration write data |
| cfg_o | output | 32 | configuration word readback |
| req_pending_i | input | 1 | front end has a request pending |
| req_grant_o | output | 1 | request may proceed to the sequencer |
| warm_rst_req_i | input | 1 | warm reset request |
| idle_req_i | input | 1 | hardware idle request |
| idle_ack_o | output | 1 | idle request acknowledged |
| dll_lock_i | input | 1 | DLL lock status |
| cke_o | output | 1 | memory clock enable |
| ext_clk_en_o | output | 1 | external memory clock enable (0 holds it at 0) |
| int_clk_en_o | output | 1 | internal controller clock enable |
| srf_enter_o | output | 1 | self-refresh entry pulse to the sequencer |
| srf_exit_o | output | 1 | self-refresh exit pulse to the sequencer |

## Verification
The assertions check a set of invariants on every cycle:
- a grant never appears without a pending request or while the internal clock is gated;
- the idle acknowledge only appears with CKE low and the external clock stopped;
- entry and exit pulses never coincide, and CKE is in the right state when each fires;
- reserved configuration bits read 0;
- no grant follows an exit cycle in DLL mode without lock.

Only the directed scenarios can show the exact N+1 idle timing, the reload on a request, the exact 500-cycle stall, and the modes in which a trigger must be ignored.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;
  localparam int unsigned CFG_W  = 32;
  localparam int unsigned IDLE_W = 16;
  localparam logic [CFG_W-1:0] CFG_RST  = 32'h0000_0085;
  localparam logic [CFG_W-1:0] CFG_MASK = 32'h04FF_FFFD;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_GATE = 2'd1,
    MODE_SRF  = 2'd2
  } auto_mode_e;

  typedef enum logic [1:0] {
    ST_ACTIVE,
    ST_GATED,
    ST_SRF,
    ST_WAKE
  } pwr_state_e;

  typedef struct packed {
    logic              wake_dll;
    logic [IDLE_W-1:0] idle_cnt;
    logic              srf_on_rst;
    logic              srf_on_idle;
    auto_mode_e        mode;
    logic              ext_clk_dis;
    logic              pwd_en;
  } cfg_t;

  function automatic cfg_t cfg_decode(input logic [CFG_W-1:0] w);
    cfg_t c;
    c.wake_dll    = w[26];
    c.idle_cnt    = w[23:8];
    c.srf_on_rst  = w[7];
    c.srf_on_idle = w[6];
    // reserved encoding 3 falls back to no automatic action
    c.mode        = (w[5:4] == 2'd3) ? MODE_OFF : auto_mode_e'(w[5:4]);
    c.ext_clk_dis = w[3];
    c.pwd_en      = w[2];
    return c;
  endfunction
endpackage

// File: rtl/spm_cfg_reg.sv
module spm_cfg_reg
  import sdram_pwr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] word_o
);
  logic [CFG_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= CFG_RST;
    else if (we_i) word_q <= wdata_i & CFG_MASK;
  end

  assign word_o = word_q;
endmodule

// File: rtl/spm_idle_timer.sv
module spm_idle_timer
  import sdram_pwr_pkg::*;
#(
  parameter int unsigned W = IDLE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         enable_i,
  input  logic         busy_i,
  input  auto_mode_e   mode_i,
  input  logic [W-1:0] load_i,
  output logic         fire_o
);
  logic [W-1:0] cnt_q;
  auto_mode_e   mode_q;
  logic         reload;

  assign reload = busy_i || !enable_i || (mode_i != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= MODE_OFF;
    end else begin
      mode_q <= mode_i;
      if (reload)          cnt_q <= load_i;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign fire_o = !reload && (cnt_q == '0);
endmodule

// File: rtl/spm_wake_stall.sv
module spm_wake_stall #(
  parameter int unsigned STALL_CYCLES = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_wake_i,
  input  logic use_dll_i,
  input  logic dll_lock_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(STALL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STALL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!in_wake_i)              cnt_q <= '0;
    else if (cnt_q != LAST)           cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = in_wake_i && (use_dll_i ? dll_lock_i : (cnt_q == LAST));
endmodule

// File: rtl/spm_pwr_fsm.sv
module spm_pwr_fsm
  import sdram_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cfg_t       cfg_i,
  input  logic       req_pending_i,
  input  logic       warm_rst_req_i,
  input  logic       idle_req_i,
  input  logic       idle_fire_i,
  input  logic       stall_done_i,
  output pwr_state_e state_o,
  output logic       req_grant_o,
  output logic       idle_ack_o,
  output logic       cke_o,
  output logic       ext_clk_en_o,
  output logic       int_clk_en_o,
  output logic       srf_enter_o,
  output logic       srf_exit_o
);
  pwr_state_e state_q, state_d;
  logic       srf_trig, enter_q, exit_q;

  assign srf_trig = (warm_rst_req_i && cfg_i.srf_on_rst) ||
                    (idle_req_i && cfg_i.srf_on_idle);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE: begin
        if (srf_trig) state_d = ST_SRF;
        else if (idle_fire_i && cfg_i.mode == MODE_GATE) state_d = ST_GATED;
        else if (idle_fire_i && cfg_i.mode == MODE_SRF)  state_d = ST_SRF;
      end
      ST_GATED: begin
        if (srf_trig)           state_d = ST_SRF;
        else if (req_pending_i) state_d = ST_WAKE;
      end
      ST_SRF:  if (req_pending_i && !srf_trig) state_d = ST_WAKE;
      ST_WAKE: if (stall_done_i) state_d = ST_ACTIVE;
      default: state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACTIVE;
      enter_q <= 1'b0;
      exit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      enter_q <= (state_d == ST_SRF) && (state_q != ST_SRF);
      exit_q  <= (state_q == ST_SRF) && (state_d == ST_WAKE);
    end
  end

  assign state_o      = state_q;
  assign req_grant_o  = (state_q == ST_ACTIVE) && req_pending_i;
  assign idle_ack_o   = (state_q == ST_SRF) && idle_req_i;
  assign cke_o        = !((state_q == ST_SRF) ||
                          ((state_q == ST_GATED) && cfg_i.pwd_en));
  assign ext_clk_en_o = !cfg_i.ext_clk_dis && (state_q != ST_SRF);
  assign int_clk_en_o = (state_q == ST_ACTIVE) || (state_q == ST_WAKE);
  assign srf_enter_o  = enter_q;
  assign srf_exit_o   = exit_q;
endmodule

// File: rtl/sdram_pwr_mgr.sv
module sdram_pwr_mgr
  import sdram_pwr_pkg::*;
#(
  parameter int unsigned STALL_CYCLES = 500
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_o,
  input  logic        req_pending_i,
  output logic        req_grant_o,
  input  logic        warm_rst_req_i,
  input  logic        idle_req_i,
  output logic        idle_ack_o,
  input  logic        dll_lock_i,
  output logic        cke_o,
  output logic        ext_clk_en_o,
  output logic        int_clk_en_o,
  output logic        srf_enter_o,
  output logic        srf_exit_o
);
  logic [CFG_W-1:0] cfg_word;
  cfg_t             cfg;
  pwr_state_e       state;
  logic             idle_fire, stall_done;

  spm_cfg_reg u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .wdata_i(cfg_wdata_i), .word_o(cfg_word)
  );

  assign cfg   = cfg_decode(cfg_word);
  assign cfg_o = cfg_word;

  spm_idle_timer #(.W(IDLE_W)) u_timer (
    .clk_i, .rst_ni,
    .enable_i ((state == ST_ACTIVE) && (cfg.mode != MODE_OFF)),
    .busy_i   (req_pending_i),
    .mode_i   (cfg.mode),
    .load_i   (cfg.idle_cnt),
    .fire_o   (idle_fire)
  );

  spm_wake_stall #(.STALL_CYCLES(STALL_CYCLES)) u_stall (
    .clk_i, .rst_ni,
    .in_wake_i (state == ST_WAKE),
    .use_dll_i (cfg.wake_dll),
    .dll_lock_i,
    .done_o    (stall_done)
  );

  spm_pwr_fsm u_fsm (
    .clk_i, .rst_ni,
    .cfg_i         (cfg),
    .req_pending_i,
    .warm_rst_req_i,
    .idle_req_i,
    .idle_fire_i   (idle_fire),
    .stall_done_i  (stall_done),
    .state_o       (state),
    .req_grant_o,
    .idle_ack_o,
    .cke_o,
    .ext_clk_en_o,
    .int_clk_en_o,
    .srf_enter_o,
    .srf_exit_o
  );
endmodule

// File: rtl/sdram_pwr_mgr_chk.sv
module sdram_pwr_mgr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] cfg_o,
  input logic        req_pending_i,
  input logic        req_grant_o,
  input logic        idle_ack_o,
  input logic        dll_lock_i,
  input logic        cke_o,
  input logic        ext_clk_en_o,
  input logic        int_clk_en_o,
  input logic        srf_enter_o,
  input logic        srf_exit_o
);
  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o[31:27] == 5'd0) && (cfg_o[25:24] == 2'd0) && !cfg_o[1]);

  assert_no_grant_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_clk_en_o |-> !req_grant_o);

  assert_enter_cke_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srf_enter_o |-> (!cke_o && !ext_clk_en_o && !int_clk_en_o));

  assert_ack_clk_stopped_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_ack_o |-> (!ext_clk_en_o && !cke_o));

  assert_exit_cke_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srf_exit_o |-> (cke_o && !req_grant_o && !srf_enter_o));

  assert_dll_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o[26] && srf_exit_o && !dll_lock_i) |=> !req_grant_o);

  assert_extclk_dis_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[3] |-> !ext_clk_en_o);

  assert_grant_req_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_grant_o |-> req_pending_i);
endmodule

bind sdram_pwr_mgr sdram_pwr_mgr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_o(cfg_o), .req_pending_i(req_pending_i),
  .req_grant_o(req_grant_o), .idle_ack_o(idle_ack_o), .dll_lock_i(dll_lock_i),
  .cke_o(cke_o), .ext_clk_en_o(ext_clk_en_o), .int_clk_en_o(int_clk_en_o),
  .srf_enter_o(srf_enter_o), .srf_exit_o(srf_exit_o)
);

// File: tb/tb_sdram_pwr_mgr.sv
`timescale 1ns/1ps
module tb_sdram_pwr_mgr;
  localparam int STALL = 500;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_o;
  logic        req_pending_i = 1'b1;
  logic        req_grant_o;
  logic        warm_rst_req_i = 1'b0;
  logic        idle_req_i = 1'b0;
  logic        idle_ack_o;
  logic        dll_lock_i = 1'b0;
  logic        cke_o, ext_clk_en_o, int_clk_en_o, srf_enter_o, srf_exit_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  sdram_pwr_mgr #(.STALL_CYCLES(STALL)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic drive_neg();
    @(negedge clk_i);
  endtask

  function automatic logic [31:0] mk(input bit dll, input int cnt, input bit on_rst,
                                     input bit on_idle, input int mode, input bit xdis,
                                     input bit pwd);
    return {5'd0, dll, 2'd0, cnt[15:0], on_rst, on_idle, mode[1:0], xdis, pwd, 2'b01};
  endfunction

  task automatic wr(input logic [31:0] v);
    drive_neg(); cfg_we_i = 1'b1; cfg_wdata_i = v;
    drive_neg(); cfg_we_i = 1'b0;
    repeat (3) tick();
  endtask

  task automatic count_idle(output int k, input int lim);
    drive_neg(); req_pending_i = 1'b0;
    k = 0;
    do begin tick(); k++; end while (int_clk_en_o && k < lim);
  endtask

  task automatic wake_fixed(input string tag);
    int k;
    drive_neg(); req_pending_i = 1'b1;
    k = 0;
    do begin tick(); k++; end while (!req_grant_o && k < 2000);
    chk(k == STALL + 1, tag, k, STALL + 1);
  endtask

  task automatic t_reset();
    chk(cfg_o == 32'h85, "R1 reset cfg", cfg_o, 32'h85);
    chk(cke_o && ext_clk_en_o && int_clk_en_o, "R1 reset outputs", {cke_o, ext_clk_en_o, int_clk_en_o}, 7);
  endtask

  task automatic t_cfg();
    wr(32'hFFFF_FFFF);
    chk(cfg_o == 32'h04FF_FFFD, "R1 rsvd ones", cfg_o, 32'h04FF_FFFD);
    wr(32'h0);
    chk(cfg_o == 32'h0, "R1 zero", cfg_o, 0);
  endtask

  task automatic t_gate();
    int k;
    wr(mk(0, 5, 0, 0, 1, 0, 1));
    count_idle(k, 100);
    chk(k == 6, "R2 gate timing", k, 6);
    chk(ext_clk_en_o, "R2 ext clk on", ext_clk_en_o, 1);
    chk(!cke_o, "R11 pwd cke low", cke_o, 0);
    wake_fixed("R9 stall from gate");
    wr(mk(0, 5, 0, 0, 1, 0, 0));
    count_idle(k, 100);
    chk(k == 6 && cke_o, "R11 pwd off cke high", cke_o, 1);
    wake_fixed("R9 stall from gate 2");
  endtask

  task automatic t_srf();
    int k;
    wr(mk(0, 3, 0, 0, 2, 0, 1));
    count_idle(k, 100);
    chk(k == 4, "R3 srf timing", k, 4);
    chk(srf_enter_o && !cke_o && !ext_clk_en_o, "R3 srf outputs",
        {srf_enter_o, cke_o, ext_clk_en_o}, 4);
    tick();
    chk(!srf_enter_o, "R3 enter one cycle", srf_enter_o, 0);
    drive_neg(); req_pending_i = 1'b1;
    tick();
    chk(srf_exit_o && cke_o && !req_grant_o, "R8 exit pulse",
        {srf_exit_o, cke_o, req_grant_o}, 6);
    k = 0;
    do begin tick(); k++; end while (!req_grant_o && k < 2000);
    chk(k == STALL, "R9 stall length", k, STALL);
    chk(!srf_exit_o, "R8 exit one cycle", srf_exit_o, 1'b0);
  endtask

  task automatic t_off();
    int k;
    wr(mk(0, 2, 0, 0, 0, 0, 1));
    count_idle(k, 50);
    chk(int_clk_en_o && cke_o, "R4 mode0 stays on", int_clk_en_o, 1);
    drive_neg(); req_pending_i = 1'b1;
    wr(mk(0, 2, 0, 0, 3, 0, 1));
    count_idle(k, 50);
    chk(int_clk_en_o && cke_o, "R4 mode3 stays on", int_clk_en_o, 1);
    drive_neg(); req_pending_i = 1'b1;
    tick();
  endtask

  task automatic t_reload();
    int k;
    wr(mk(0, 8, 0, 0, 1, 0, 1));
    drive_neg(); req_pending_i = 1'b0;
    repeat (5) tick();
    chk(int_clk_en_o, "R5 not yet gated", int_clk_en_o, 1);
    drive_neg(); req_pending_i = 1'b1;
    count_idle(k, 100);
    chk(k == 9, "R5 reload restarts", k, 9);
    wake_fixed("R9 stall after reload");
  endtask

  task automatic t_warm();
    wr(mk(0, 0, 0, 0, 0, 0, 1));
    drive_neg(); req_pending_i = 1'b0; warm_rst_req_i = 1'b1;
    repeat (5) tick();
    chk(cke_o && !srf_enter_o, "R6 warm ignored", cke_o, 1);
    drive_neg(); warm_rst_req_i = 1'b0;
    wr(mk(0, 0, 1, 0, 0, 0, 1));
    drive_neg(); warm_rst_req_i = 1'b1;
    tick();
    chk(!cke_o && !ext_clk_en_o, "R6 warm enters srf", cke_o, 0);
    drive_neg(); warm_rst_req_i = 1'b0;
    wake_fixed("R9 stall after warm");
  endtask

  task automatic t_idle();
    bit seen;
    wr(mk(0, 0, 0, 0, 0, 0, 1));
    drive_neg(); req_pending_i = 1'b0; idle_req_i = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin tick(); seen |= idle_ack_o | !cke_o; end
    chk(!seen, "R7 idle ignored", seen, 0);
    drive_neg(); idle_req_i = 1'b0;
    wr(mk(0, 0, 0, 1, 0, 0, 1));
    chk(!idle_ack_o, "R7 no early ack", idle_ack_o, 0);
    drive_neg(); idle_req_i = 1'b1;
    tick();
    chk(idle_ack_o && !ext_clk_en_o && !cke_o, "R7 ack in srf",
        {idle_ack_o, ext_clk_en_o, cke_o}, 4);
    drive_neg(); idle_req_i = 1'b0;
    tick();
    chk(!idle_ack_o, "R7 ack drops", idle_ack_o, 0);
    wake_fixed("R9 stall after idle");
  endtask

  task automatic t_dll();
    int k;
    bit bad;
    wr(mk(1, 1, 0, 0, 2, 0, 1));
    count_idle(k, 100);
    chk(k == 2 && !cke_o, "R3 srf N=1", k, 2);
    drive_neg(); req_pending_i = 1'b1; dll_lock_i = 1'b0;
    bad = 1'b0;
    for (int i = 0; i < 600; i++) begin tick(); bad |= req_grant_o; end
    chk(!bad, "R10 held without lock", bad, 0);
    drive_neg(); dll_lock_i = 1'b1;
    tick();
    chk(req_grant_o, "R10 grant after lock", req_grant_o, 1);
    drive_neg(); dll_lock_i = 1'b0;
  endtask

  task automatic t_ext_grant();
    wr(mk(0, 0, 0, 0, 0, 1, 1));
    chk(!ext_clk_en_o, "R12 ext clk disabled", ext_clk_en_o, 0);
    chk(req_grant_o, "R13 grant with req", req_grant_o, 1);
    drive_neg(); req_pending_i = 1'b0;
    tick();
    chk(!req_grant_o, "R13 no grant idle", req_grant_o, 0);
    drive_neg(); req_pending_i = 1'b1;
    wr(mk(0, 0, 0, 0, 0, 0, 1));
    chk(ext_clk_en_o, "R12 ext clk back", ext_clk_en_o, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    drive_neg(); rst_ni = 1'b1;
    tick();
    t_cfg();
    t_gate();
    t_srf();
    t_off();
    t_reload();
    t_warm();
    t_idle();
    t_dll();
    t_ext_grant();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule